// File: doc/BRIEF.md
# Memory Error Statistics Counter Bank

This block tallies the error events that a memory ECC checker reports. Each event arrives as a one-cycle strobe, together with a bit saying whether the error was fixed (correctable) or beyond repair (uncorrectable), a flag saying whether the checker knew where the error happened, and a channel and slot index. The block keeps several views of these events at once. It has controller-wide totals per class, separate counts of events that carry no usable location, a counter pair for each physical module position, and a counter pair for each slot number that is shared by all channels. It also keeps a seconds counter, driven by a one-second tick, that shows how long ago the statistics were last cleared.

Software reads any counter through a registered read port. A clear command zeroes all statistics and the seconds value. An optional halt policy turns an uncorrectable event into a sticky halt request, and such an event is then not counted. A log strobe, gated separately for each class, reports each accepted event. It carries the event's flat row number, which counts only the populated module positions and runs through channels first and then slots.

Top module: `mem_err_tally`

## Requirements
- R1: An event with `evt_uncorr`=0 is correctable and one with `evt_uncorr`=1 is uncorrectable. A located event at channel c, slot s increments the per-module counter of its class at flat position m = c*NUM_SLOT+s. That counter reads at address 8+2m for correctable and 9+2m for uncorrectable.
- R2: The controller totals count every counted event, whether located or not: correctable at address 0 and uncorrectable at address 1. An event is located only when `evt_loc_ok`=1 and `present[m]`=1. Events that are not located count in the no-location counters instead of any module or slot counter: correctable at address 2 and uncorrectable at address 3.
- R3: A cycle with `clr_cnt`=1 zeroes every counter and the seconds value, starting from the next cycle.
- R4: Each cycle with `tick_1s`=1 adds one to the seconds value at address 4. The value saturates at 2^SEC_W-1.
- R5: With `panic_en`=1, an uncorrectable event sets `halt` in the next cycle, and `halt` then stays high until `rst_n` is asserted. No uncorrectable counter of any view changes for that event. Correctable counting is unaffected.
- R6: `log_stb` pulses one cycle after a counted event when the enable of its class (`log_ce_en` or `log_ue_en`) is high, with `log_uncorr` giving the class. Counting does not depend on these enables.
- R7: A located event at slot s of any channel increments a shared slot counter pair: correctable at address 8+2*NMOD+2s and uncorrectable at the next address.
- R8: With a log pulse, `log_loc` is 1 for a located event. In that case `log_row` equals the number of present positions whose flat index is below the event's own, and otherwise it is 0.
- R9: Every error counter stops at 2^CNT_W-1 and does not wrap.
- R10: An event in the same cycle as `clr_cnt` is dropped. It changes no counter, produces no log pulse and does not set `halt`.
- R11: `rd_data` is loaded one cycle after a cycle with `rd_en`=1, with the addressed value as it stood before that cycle's update. It holds that value until the next read. Unmapped addresses read 0.
- R12: After reset, all counters, the seconds value, `halt`, `log_stb` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event strobe |
| evt_uncorr | input | 1 | 1 for uncorrectable, 0 for correctable |
| evt_loc_ok | input | 1 | Event carries a valid location |
| evt_ch | input | CH_W | Channel index of the event |
| evt_slot | input | SL_W | Slot index within the channel |
| present | input | NUM_CH*NUM_SLOT | Populated mask, bit m for flat position m |
| clr_cnt | input | 1 | Clear all statistics |
| tick_1s | input | 1 | One-second tick |
| panic_en | input | 1 | Halt on uncorrectable policy |
| log_ce_en | input | 1 | Log enable for correctable events |
| log_ue_en | input | 1 | Log enable for uncorrectable events |
| rd_en | input | 1 | Read request |
| rd_addr | input | A_W | Read address |
| rd_data | output | SEC_W | Registered read value |
| halt | output | 1 | Sticky halt request |
| log_stb | output | 1 | Log event pulse |
| log_uncorr | output | 1 | Class of the logged event |
| log_loc | output | 1 | Logged event was located |
| log_row | output | MOD_W | Flat populated-row number of the logged event |

## Verification
The assertions assume that `evt_ch` and `evt_slot` are always below NUM_CH and NUM_SLOT, and that SEC_W is at least CNT_W. The bench only drives channel and slot values inside the configured ranges. It changes `present` only between events. It drives every input on the falling edge, so each event is a clean single-cycle strobe, and the saturation checks only reach the counter limit through that normal sequence of events.

// File: rtl/mem_err_tally.sv
module mem_err_tally #(
  parameter int NUM_CH   = 2,
  parameter int NUM_SLOT = 4,
  parameter int CNT_W    = 16,
  parameter int SEC_W    = 32,
  localparam int NMOD      = NUM_CH * NUM_SLOT,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SL_W      = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int MOD_W     = (NMOD > 1) ? $clog2(NMOD) : 1,
  localparam int MOD_BASE  = 8,
  localparam int SLOT_BASE = MOD_BASE + 2 * NMOD,
  localparam int A_W       = $clog2(SLOT_BASE + 2 * NUM_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic             evt_uncorr,
  input  logic             evt_loc_ok,
  input  logic [CH_W-1:0]  evt_ch,
  input  logic [SL_W-1:0]  evt_slot,
  input  logic [NMOD-1:0]  present,
  input  logic             clr_cnt,
  input  logic             tick_1s,
  input  logic             panic_en,
  input  logic             log_ce_en,
  input  logic             log_ue_en,
  input  logic             rd_en,
  input  logic [A_W-1:0]   rd_addr,
  output logic [SEC_W-1:0] rd_data,
  output logic             halt,
  output logic             log_stb,
  output logic             log_uncorr,
  output logic             log_loc,
  output logic [MOD_W-1:0] log_row
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [SEC_W-1:0] SMAX = {SEC_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  logic [MOD_W-1:0] mod_idx;
  logic             located, take, inc_ce, inc_ue;
  logic [MOD_W-1:0] row_idx;

  logic [CNT_W-1:0] ce_total, ue_total, ce_noloc, ue_noloc;
  logic [SEC_W-1:0] secs;
  logic [CNT_W-1:0] mod_ce  [NMOD];
  logic [CNT_W-1:0] mod_ue  [NMOD];
  logic [CNT_W-1:0] slot_ce [NUM_SLOT];
  logic [CNT_W-1:0] slot_ue [NUM_SLOT];
  logic [SEC_W-1:0] rd_mux;

  assign mod_idx = MOD_W'(int'(evt_ch) * NUM_SLOT + int'(evt_slot));
  assign located = evt_loc_ok & present[mod_idx];
  assign take    = evt_valid & ~clr_cnt;
  assign inc_ce  = take & ~evt_uncorr;
  assign inc_ue  = take & evt_uncorr & ~panic_en;

  always_comb begin
    row_idx = '0;
    for (int i = 0; i < NMOD; i++)
      if (MOD_W'(i) < mod_idx && present[i]) row_idx = row_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_cnt) begin
      ce_total <= '0;
      ue_total <= '0;
      ce_noloc <= '0;
      ue_noloc <= '0;
    end else begin
      if (inc_ce) ce_total <= bump(ce_total);
      if (inc_ue) ue_total <= bump(ue_total);
      if (inc_ce && !located) ce_noloc <= bump(ce_noloc);
      if (inc_ue && !located) ue_noloc <= bump(ue_noloc);
    end
  end

  for (genvar g = 0; g < NMOD; g++) begin : g_mod
    logic hit;
    assign hit = located && (mod_idx == MOD_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_cnt) begin
        mod_ce[g] <= '0;
        mod_ue[g] <= '0;
      end else begin
        if (inc_ce && hit) mod_ce[g] <= bump(mod_ce[g]);
        if (inc_ue && hit) mod_ue[g] <= bump(mod_ue[g]);
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic hit;
    assign hit = located && (evt_slot == SL_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_cnt) begin
        slot_ce[s] <= '0;
        slot_ue[s] <= '0;
      end else begin
        if (inc_ce && hit) slot_ce[s] <= bump(slot_ce[s]);
        if (inc_ue && hit) slot_ue[s] <= bump(slot_ue[s]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_cnt) secs <= '0;
    else if (tick_1s && secs != SMAX) secs <= secs + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) halt <= 1'b0;
    else if (take && evt_uncorr && panic_en) halt <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_stb    <= 1'b0;
      log_uncorr <= 1'b0;
      log_loc    <= 1'b0;
      log_row    <= '0;
    end else begin
      log_stb    <= take & (evt_uncorr ? log_ue_en : log_ce_en);
      log_uncorr <= evt_uncorr;
      log_loc    <= located;
      log_row    <= located ? row_idx : '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_W'(0)) rd_mux = SEC_W'(ce_total);
    if (rd_addr == A_W'(1)) rd_mux = SEC_W'(ue_total);
    if (rd_addr == A_W'(2)) rd_mux = SEC_W'(ce_noloc);
    if (rd_addr == A_W'(3)) rd_mux = SEC_W'(ue_noloc);
    if (rd_addr == A_W'(4)) rd_mux = secs;
    for (int i = 0; i < NMOD; i++) begin
      if (rd_addr == A_W'(MOD_BASE + 2 * i))     rd_mux = SEC_W'(mod_ce[i]);
      if (rd_addr == A_W'(MOD_BASE + 2 * i + 1)) rd_mux = SEC_W'(mod_ue[i]);
    end
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (rd_addr == A_W'(SLOT_BASE + 2 * i))     rd_mux = SEC_W'(slot_ce[i]);
      if (rd_addr == A_W'(SLOT_BASE + 2 * i + 1)) rd_mux = SEC_W'(slot_ue[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_noloc_le_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_noloc <= ce_total) && (ue_noloc <= ue_total));

  assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (ce_total == '0 && ue_total == '0 && secs == '0));

  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_ue_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_uncorr && panic_en && !clr_cnt) |=> (ue_total == $past(ue_total)));

  assert_log_follows_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_stb) |-> $past(evt_valid));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_total == CMAX && !clr_cnt) |=> (ce_total == CMAX));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> !log_stb);

  assert_read_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/mem_err_tally_bench.sv
module mem_err_tally_bench;
  localparam int NC = 2, NS = 4, CW = 4, SW = 8;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_uncorr = 0, evt_loc_ok = 0;
  logic [0:0] evt_ch = '0;
  logic [1:0] evt_slot = '0;
  logic [7:0] present = 8'hFF;
  logic clr_cnt = 0, tick_1s = 0, panic_en = 0, log_ce_en = 1, log_ue_en = 1;
  logic rd_en = 0;
  logic [4:0] rd_addr = '0;
  logic [SW-1:0] rd_data;
  logic halt, log_stb, log_uncorr, log_loc;
  logic [2:0] log_row;

  int checks = 0, fails = 0;
  logic lg_stb, lg_unc, lg_loc;
  logic [2:0] lg_row;

  mem_err_tally #(.NUM_CH(NC), .NUM_SLOT(NS), .CNT_W(CW), .SEC_W(SW)) u_mem_err_tally (
    .clk, .rst_n, .evt_valid, .evt_uncorr, .evt_loc_ok, .evt_ch, .evt_slot, .present,
    .clr_cnt, .tick_1s, .panic_en, .log_ce_en, .log_ue_en, .rd_en, .rd_addr,
    .rd_data, .halt, .log_stb, .log_uncorr, .log_loc, .log_row);

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic unc, input logic loc, input int ch, input int sl);
    @(negedge clk);
    evt_valid = 1; evt_uncorr = unc; evt_loc_ok = loc;
    evt_ch = 1'(ch); evt_slot = 2'(sl);
    @(negedge clk);
    evt_valid = 0;
    lg_stb = log_stb; lg_unc = log_uncorr; lg_loc = log_loc; lg_row = log_row;
  endtask

  task automatic rd(input int addr, output int val);
    @(negedge clk);
    rd_en = 1; rd_addr = 5'(addr);
    @(negedge clk);
    rd_en = 0;
    val = int'(rd_data);
  endtask

  task automatic clear();
    @(negedge clk); clr_cnt = 1;
    @(negedge clk); clr_cnt = 0;
  endtask

  task automatic t_reset();
    int v;
    chk("R12 rd_data", int'(rd_data), 0);
    chk("R12 halt", int'(halt), 0);
    chk("R12 log_stb", int'(log_stb), 0);
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R12 counter", v, 0); end
    rd(8, v); chk("R12 module", v, 0);
  endtask

  task automatic t_classify();
    int v;
    clear();
    send(0, 1, 1, 2);
    chk("R6 log pulse ce", int'(lg_stb), 1);
    chk("R6 log class ce", int'(lg_unc), 0);
    chk("R8 row all present", int'(lg_row), 6);
    chk("R8 loc flag", int'(lg_loc), 1);
    send(1, 1, 0, 1);
    chk("R6 log class ue", int'(lg_unc), 1);
    rd(20, v); chk("R1 module6 ce", v, 1);
    rd(21, v); chk("R1 module6 ue", v, 0);
    rd(11, v); chk("R1 module1 ue", v, 1);
    rd(0, v);  chk("R2 ce total", v, 1);
    rd(1, v);  chk("R2 ue total", v, 1);
    send(0, 1, 0, 2);
    rd(28, v); chk("R7 slot2 ce shared", v, 2);
    rd(27, v); chk("R7 slot1 ue", v, 1);
  endtask

  task automatic t_noloc();
    int v;
    clear();
    send(0, 0, 0, 0);
    send(1, 0, 1, 1);
    present = 8'b1111_0111;
    send(0, 1, 0, 3);
    chk("R8 unpopulated not located", int'(lg_loc), 0);
    present = 8'hFF;
    rd(2, v);  chk("R2 ce noloc", v, 2);
    rd(3, v);  chk("R2 ue noloc", v, 1);
    rd(8, v);  chk("R2 module0 untouched", v, 0);
    rd(14, v); chk("R2 module3 untouched", v, 0);
    rd(30, v); chk("R2 slot3 untouched", v, 0);
    rd(0, v);  chk("R2 total includes noloc", v, 2);
  endtask

  task automatic t_row();
    clear();
    present = 8'b1010_0101;
    send(0, 1, 1, 3);
    chk("R8 row of position7", int'(lg_row), 3);
    send(0, 1, 1, 1);
    chk("R8 row of position5", int'(lg_row), 2);
    send(0, 1, 0, 0);
    chk("R8 row of position0", int'(lg_row), 0);
    present = 8'hFF;
  endtask

  task automatic t_log();
    int v;
    clear();
    log_ce_en = 0;
    send(0, 1, 0, 0);
    chk("R6 ce log gated", int'(lg_stb), 0);
    log_ue_en = 1;
    send(1, 1, 0, 0);
    chk("R6 ue log on", int'(lg_stb), 1);
    log_ue_en = 0;
    send(1, 1, 0, 0);
    chk("R6 ue log gated", int'(lg_stb), 0);
    rd(0, v); chk("R6 ce counted while gated", v, 1);
    rd(1, v); chk("R6 ue counted while gated", v, 2);
    log_ce_en = 1; log_ue_en = 1;
  endtask

  task automatic t_sat();
    int v;
    clear();
    for (int i = 0; i < 20; i++) send(0, 1, 0, 0);
    rd(8, v);  chk("R9 module saturates", v, 15);
    rd(0, v);  chk("R9 total saturates", v, 15);
    rd(24, v); chk("R9 slot saturates", v, 15);
  endtask

  task automatic t_secs();
    int v;
    clear();
    for (int i = 0; i < 5; i++) begin @(negedge clk); tick_1s = 1; @(negedge clk); tick_1s = 0; end
    rd(4, v); chk("R4 seconds count", v, 5);
    @(negedge clk); tick_1s = 1;
    repeat (300) @(negedge clk);
    tick_1s = 0;
    rd(4, v); chk("R4 seconds saturate", v, 255);
    send(1, 1, 1, 0);
    clear();
    rd(4, v);  chk("R3 seconds cleared", v, 0);
    rd(1, v);  chk("R3 ue total cleared", v, 0);
    rd(17, v); chk("R3 module cleared", v, 0);
    rd(25, v); chk("R3 slot cleared", v, 0);
  endtask

  task automatic t_clr_vs_evt();
    int v;
    clear();
    @(negedge clk);
    clr_cnt = 1; evt_valid = 1; evt_uncorr = 1; evt_loc_ok = 1; evt_ch = 0; evt_slot = 0;
    panic_en = 1;
    @(negedge clk);
    clr_cnt = 0; evt_valid = 0; panic_en = 0;
    chk("R10 no log", int'(log_stb), 0);
    chk("R10 no halt", int'(halt), 0);
    rd(1, v); chk("R10 no count", v, 0);
  endtask

  task automatic t_snapshot();
    int v;
    clear();
    send(0, 1, 0, 0);
    rd(0, v); chk("R11 read value", v, 1);
    send(0, 1, 0, 0);
    chk("R11 holds without read", int'(rd_data), 1);
    @(negedge clk);
    rd_en = 1; rd_addr = 0; evt_valid = 1; evt_uncorr = 0; evt_loc_ok = 1;
    @(negedge clk);
    rd_en = 0; evt_valid = 0;
    chk("R11 pre-update value", int'(rd_data), 2);
    rd(31, v); chk("R11 slot3 ue read", v, 0);
  endtask

  task automatic t_panic();
    int v;
    clear();
    panic_en = 1;
    send(0, 1, 0, 0);
    chk("R5 ce no halt", int'(halt), 0);
    send(1, 1, 0, 0);
    chk("R5 halt set", int'(halt), 1);
    send(1, 0, 0, 0);
    rd(1, v);  chk("R5 ue total blocked", v, 0);
    rd(9, v);  chk("R5 module ue blocked", v, 0);
    rd(25, v); chk("R5 slot ue blocked", v, 0);
    rd(3, v);  chk("R5 noloc ue blocked", v, 0);
    panic_en = 0;
    send(0, 1, 0, 0);
    rd(0, v);  chk("R5 ce still counts", v, 2);
    clear();
    chk("R5 halt sticky over clear", int'(halt), 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_noloc();
    t_row();
    t_log();
    t_sat();
    t_secs();
    t_clr_vs_evt();
    t_snapshot();
    t_panic();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule